// File: doc/BRIEF.md
# Three-Wire Latched Register Loader

This block takes 17-bit command frames from a three-wire serial link and turns each one into a register write. The link has a frame strobe, a bit clock and a data line. The loader keeps a bank of nineteen 10-bit setting registers. Each register sets one analog level further down the chip. The last register, index 18, sets the common-voltage level. The loader also keeps a single flag that chooses between an internal and an external oscillator.

All three link wires come from outside the system clock domain. Each wire passes through a two-flop synchroniser, and all edges are detected with the system clock. While the strobe is low, every rising edge of the bit clock shifts one bit in. When the strobe rises, the frame is committed, but only if at least 17 bits arrived since the previous strobe rise. A frame that is too short is dropped. A frame that is too long keeps only its newest 17 bits. A synchronous reset returns every register and the oscillator flag to zero.

Top module: `tw_frame_loader`

## Requirements
- R1: While `rst` is high, every register in `reg_bank` and `osc_external` are cleared to 0 on the next clock edge.
- R2: A bit is taken from `frm_data` on each rising edge of `frm_clk` while `frm_latch` is low. The first bit taken is d0 and the seventeenth is d16. The frame is committed on the rising edge of `frm_latch`. A committed frame writes d7..d16 (d7 is the MSB) into the addressed register within 8 system clocks.
- R3: Bits d2..d6 form the register address, with d2 as the MSB. Address k, for k from 0 to 18, writes register k, which appears at `reg_bank[k*10 +: 10]`. No other register changes.
- R4: Every committed frame loads its d1 bit into `osc_external`, where 1 means external clock and 0 means internal clock. This includes frames whose write is rejected.
- R5: If fewer than 17 bits were shifted in since the last strobe rise, the frame is dropped at the strobe rise. This covers zero bits as well. Neither the registers nor `osc_external` change.
- R6: If more than 17 bits were shifted in, only the last 17 bits received form the frame.
- R7: A committed frame with d0 = 1 leaves every register unchanged.
- R8: A committed frame whose address is 19 to 31 leaves every register unchanged.
- R9: Pulses on `frm_clk` while `frm_latch` is high shift nothing in and change no output. Outside a commit, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than the link bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_latch | input | 1 | Frame strobe: low while bits are shifted in, rising edge commits the frame |
| frm_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| frm_data | input | 1 | Serial data, d0 first |
| reg_bank | output | 190 | Nineteen 10-bit registers, register k at bits k*10+9 down to k*10 |
| osc_external | output | 1 | Oscillator select: 1 external, 0 internal |

## Verification
The assertions assume that the link wires change slowly compared with the system clock. A level must hold for several system cycles so that the synchronisers can pass every bit-clock edge and every strobe edge. They also assume that the data line is steady around each rising edge of the bit clock. The stimulus drives all wires on the falling edge of the system clock and holds every level for four system cycles. The data line is set a full half-period before each rising edge of the bit clock. After each strobe rise the stimulus waits eight cycles, so a commit is finished before the next frame starts.

// File: rtl/tw_frame_loader.sv
module tw_frame_loader #(
  parameter int NREG = 19,
  parameter int DW   = 10,
  parameter int AW   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frm_latch,
  input  logic                 frm_clk,
  input  logic                 frm_data,
  output logic [NREG*DW-1:0]   reg_bank,
  output logic                 osc_external
);
  localparam int FRAME = 2 + AW + DW;
  localparam int CW    = $clog2(FRAME + 1);

  logic [2:0] lat_q;
  logic [2:0] sck_q;
  logic [1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '1;
      sck_q <= '0;
      dat_q <= '0;
    end else begin
      lat_q <= {lat_q[1:0], frm_latch};
      sck_q <= {sck_q[1:0], frm_clk};
      dat_q <= {dat_q[0], frm_data};
    end
  end

  logic lat_rise, bit_stb;
  assign lat_rise = lat_q[1] & ~lat_q[2];
  assign bit_stb  = sck_q[1] & ~sck_q[2] & ~lat_q[1];

  logic [FRAME-1:0] shreg;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (lat_rise) begin
      cnt <= '0;
    end else if (bit_stb) begin
      shreg <= {shreg[FRAME-2:0], dat_q[1]};
      if (cnt != CW'(FRAME)) cnt <= cnt + 1'b1;
    end
  end

  logic          commit, test_bit, osc_bit, store;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;

  assign commit   = lat_rise & (cnt == CW'(FRAME));
  assign test_bit = shreg[FRAME-1];
  assign osc_bit  = shreg[FRAME-2];
  assign addr     = shreg[FRAME-3 -: AW];
  assign data     = shreg[DW-1:0];
  assign store    = commit & ~test_bit & ({1'b0, addr} < (AW+1)'(NREG));

  always_ff @(posedge clk) begin
    if (rst)         osc_external <= 1'b0;
    else if (commit) osc_external <= osc_bit;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] val;
    always_ff @(posedge clk) begin
      if (rst)                             val <= '0;
      else if (store && addr == AW'(i))    val <= data;
    end
    assign reg_bank[i*DW +: DW] = val;
  end
endmodule

// File: rtl/tw_frame_loader_chk.sv
module tw_frame_loader_chk #(
  parameter int NREG = 19,
  parameter int DW   = 10,
  parameter int AW   = 5,
  parameter int CW   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               lat_rise,
  input logic [CW-1:0]      cnt,
  input logic               test_bit,
  input logic               osc_bit,
  input logic [AW-1:0]      addr,
  input logic [NREG*DW-1:0] reg_bank,
  input logic               osc_external
);
  localparam int FRAME = 2 + AW + DW;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (reg_bank == '0 && !osc_external));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !lat_rise |=> ($stable(reg_bank) && $stable(osc_external)));

  p_short_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && cnt != CW'(FRAME)) |=> ($stable(reg_bank) && $stable(osc_external)));

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(FRAME));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

  p_osc_load_r4: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && cnt == CW'(FRAME)) |=> (osc_external == $past(osc_bit)));

  p_test_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && cnt == CW'(FRAME) && test_bit) |=> $stable(reg_bank));

  p_addr_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && cnt == CW'(FRAME) && {1'b0, addr} >= (AW+1)'(NREG)) |=> $stable(reg_bank));
endmodule

bind tw_frame_loader tw_frame_loader_chk #(
  .NREG(NREG), .DW(DW), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .lat_rise(lat_rise), .cnt(cnt), .test_bit(test_bit),
  .osc_bit(osc_bit), .addr(addr), .reg_bank(reg_bank), .osc_external(osc_external)
);

// File: tb/sim_tw_frame_loader.sv
module sim_tw_frame_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 19;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lat = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  wire [NR*DW-1:0] bank;
  wire             osc;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_frame_loader u0 (
    .clk(clk), .rst(rst), .frm_latch(lat), .frm_clk(sck), .frm_data(sdi),
    .reg_bank(bank), .osc_external(osc)
  );

  logic [NR*DW-1:0] m_img = '0;
  logic             m_osc = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NR*DW-1:0] img_q[$];
  logic             osc_q[$];
  string            tag_q[$];

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    img_q.push_back(m_img);
    osc_q.push_back(m_osc);
    tag_q.push_back(tag);
    idle(2);
  endtask

  function automatic logic [16:0] mk(input bit t, input bit o, input int a, input int d);
    return {t, o, 5'(a), 10'(d)};
  endfunction

  task automatic shift(input logic [63:0] bits, input int n, input bit open_frame);
    if (open_frame) begin lat = 1'b0; idle(4); end
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      idle(4);
      sck = 1'b1;
      idle(4);
      sck = 1'b0;
    end
    idle(4);
  endtask

  task automatic frame(input logic [63:0] bits, input int n, input string tag);
    logic [16:0] f;
    shift(bits, n, 1'b1);
    lat = 1'b1;
    idle(8);
    if (n >= 17) begin
      f = bits[16:0];
      m_osc = f[15];
      if (!f[16] && f[14:10] < 5'd19) m_img[int'(f[14:10])*DW +: DW] = f[9:0];
    end
    expect_now(tag);
  endtask

  initial begin
    forever begin
      wait (img_q.size() > 0);
      @(negedge clk);
      begin
        logic [NR*DW-1:0] ei;
        logic             eo;
        string            tg;
        ei = img_q.pop_front();
        eo = osc_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (bank !== ei || osc !== eo) begin
          errors++;
          $display("FAIL %s bank=%h osc=%b expected bank=%h osc=%b", tg, bank, osc, ei, eo);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(3);
    expect_now("R1 reset state");

    frame(64'(mk(0, 0, 0, 10'h2A5)), 17, "R2 write reg0");
    frame(64'(mk(0, 1, 18, 10'h3FF)), 17, "R4 osc external with reg18");
    frame(64'(mk(0, 0, 18, 10'h155)), 17, "R3 common reg overwrite");
    for (int a = 0; a < NR; a++)
      frame(64'(mk(0, a % 2, a, a * 53 + 7)), 17, "R3 address sweep");

    frame(64'(mk(0, 1, 6, 10'h0C3)), 17, "R4 osc set");
    frame(64'(mk(0, 0, 4, 10'h001)) >> 1, 16, "R5 sixteen bits dropped");
    frame(64'(1'b1), 1, "R5 one bit dropped");
    frame(64'd0, 0, "R5 empty strobe dropped");

    frame({44'd0, 3'b101, mk(0, 1, 7, 10'h0F0)}, 20, "R6 twenty bits");
    frame({23'h5A5A5A, 24'd0, mk(0, 0, 11, 10'h2DB)} & 64'hFF_FFFF_FFFF, 40, "R6 forty bits");

    frame(64'(mk(0, 1, 2, 10'h200)), 17, "R4 osc back to external");
    frame(64'(mk(1, 0, 3, 10'h111)), 17, "R7 test bit set");
    frame(64'(mk(1, 1, 9, 10'h3C3)), 17, "R7 test bit set osc external");
    frame(64'(mk(0, 0, 19, 10'h2AA)), 17, "R8 address 19");
    frame(64'(mk(0, 1, 31, 10'h155)), 17, "R8 address 31");

    shift(64'(mk(0, 0, 2, 10'h3AB)), 17, 1'b0);
    expect_now("R9 clocks with strobe high");
    frame(64'(mk(0, 1, 5, 10'h0AA)), 17, "R9 next frame after high clocks");

    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    m_img = '0;
    m_osc = 1'b0;
    idle(3);
    expect_now("R1 reset after writes");

    wait (img_q.size() == 0);
    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule